// File: doc/BRIEF.md
# Serial Register Access Master

This block is a hardware master that reads and writes the byte-wide control registers of a serial audio receiver over a four-wire link: an active-low select, a serial clock, an output data line and an input data line. A host issues one command at a time: a read/write flag, a 7-bit device address, an 8-bit register index and, for writes, an 8-bit value. The block then produces the framed serial transaction on its own. When it finishes it raises `done` for one clock, and for a read it also returns the byte it fetched.

A write is a single frame of three bytes. A read is split into two frames. The first frame sends the device address with its direction bit clear, followed by the register index. Select is then released for a programmable gap. The second frame sends the device address with the direction bit set, and the block clocks in one byte. The timing of every clock phase is stretched by a parameter that sets how many system clocks each phase lasts, so the same block can serve receivers of different speeds.

Top module: `spiacc_master`

## Requirements
- R1: After reset and whenever no transaction is running, `cs_n` is 1, `sclk` is 1, `mosi` is 0, and `busy` and `done` are 0.
- R2: A `start` sampled while idle begins a transaction: `busy` is 1 from the next cycle and `cs_n` goes low on that cycle. A `start` sampled while `busy` is 1 is ignored and leaves the current frame and all later output unchanged.
- R3: Every clock phase lasts exactly PHASE_CLKS system clocks. A write takes 73 phases and a read takes 98+GAP_PHASES phases, counted from the clock edge that accepts `start` to the edge that raises `done`. `sclk` stays 1 while `cs_n` is 1.
- R4: Each bit takes three phases in this order: `sclk` driven low, then `mosi` updated to the bit, then `sclk` driven high. Within a frame, `mosi` does not change while `sclk` is high.
- R5: Bytes go out most significant bit first, and each byte takes eight rising edges of `sclk`.
- R6: A write frame has 24 bits. The first byte carries the device address in bits 7..1 and 0 in bit 0 (address 7'h10 gives 0x20). The register index follows, then the write value.
- R7: A read sends a 16-bit frame made of {address, 0} and then the index. `cs_n` then stays 1 for GAP_PHASES phases. A second 16-bit frame follows, sending {address, 1} and then eight input bits.
- R8: During each input bit, `miso` is sampled at the end of the phase in which `sclk` is low and data is settled, before `sclk` rises. The eight samples form `rdata` MSB first, and `rdata` is valid when `done` is 1.
- R9: `done` is 1 for exactly one cycle: the first cycle with `cs_n` high at the end of the final frame. It is not raised at the release in the middle of a read. `busy` is 0 in that same cycle.
- R10: After `cs_n` falls, `sclk` stays high for exactly one phase before its first falling edge in each frame.
- R11: `mosi` is 0 whenever `cs_n` is 1 and during the eight input bits of a read.
- R12: A write transaction leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, sampled while idle |
| rd_nwr | input | 1 | 1 selects read, 0 selects write |
| chip_addr | input | CHIP_W | Device address placed in bits 7..1 of the first byte |
| map_addr | input | MAP_W | Register index |
| wdata | input | DATA_W | Value to write |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Byte returned by the last read |
| cs_n | output | 1 | Active-low select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the receiver |
| miso | input | 1 | Serial data from the receiver |

## Verification
The bench contains a behavioural receiver that records every frame it clocks in and, during a read, shifts out a chosen byte on falling clock edges. Three kinds of fault are targeted:
- A direction bit placed wrongly, or a byte sent LSB first, shows up as a recorded frame value that differs from the one computed in the bench.
- A wrong phase count, a missing setup phase or a gap of the wrong length changes the number of cycles the bench measures from acceptance to `done`.
- Sampling `miso` on the wrong phase, or letting a start issued mid-transfer restart the sequencer, corrupts `rdata` or the frame count.

A `done` raised at the release in the middle of a read, or held for two cycles, is caught by counting pulses.

// File: rtl/spiacc_pkg.sv
package spiacc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_BIT,
      ST_GAP
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_LOW,
      PH_DATA,
      PH_HIGH
   } bit_phase_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/spiacc_phase_timer.sv
module spiacc_phase_timer #(
   parameter int unsigned PHASE_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW   = spiacc_pkg::cnt_width(PHASE_CLKS);
   localparam int unsigned LAST = PHASE_CLKS - 1;

   generate
      if (PHASE_CLKS < 1) begin : g_bad_phase
         $error("PHASE_CLKS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tick = run && (cnt_q == CW'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/spiacc_sequencer.sv
module spiacc_sequencer
   import spiacc_pkg::*;
#(
   parameter int unsigned CHIP_W     = 7,
   parameter int unsigned MAP_W      = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned GAP_PHASES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   input  logic rd_nwr,
   output logic busy,
   output logic done,
   output logic cs_n,
   output logic sclk,
   output logic load_first,
   output logic load_second,
   output logic drive_bit,
   output logic sample_bit,
   output logic shift_bit,
   output logic end_frame,
   output logic commit_rd
);
   localparam int unsigned FR_WR   = CHIP_W + 1 + MAP_W + DATA_W;
   localparam int unsigned FR_RA   = CHIP_W + 1 + MAP_W;
   localparam int unsigned FR_RB   = CHIP_W + 1 + DATA_W;
   localparam int unsigned CNT_W   = cnt_width(FR_WR);
   localparam int unsigned GAP_W   = cnt_width(GAP_PHASES);

   generate
      if (GAP_PHASES < 1) begin : g_bad_gap
         $error("GAP_PHASES must be at least 1");
      end
      if (CHIP_W + 1 != DATA_W) begin : g_bad_addr
         $error("address byte must be as wide as the data byte");
      end
   endgenerate

   seq_state_e       state_q;
   bit_phase_e       sub_q;
   logic [CNT_W-1:0] bits_left_q;
   logic [CNT_W-1:0] frame_last;
   logic [GAP_W-1:0] gap_q;
   logic             rd_q;
   logic             second_q;
   logic             cs_n_q;
   logic             sclk_q;
   logic             done_q;
   logic             in_bit;
   logic             last_bit;

   assign in_bit      = (state_q == ST_BIT) && tick;
   assign last_bit    = (bits_left_q == '0);
   assign load_first  = (state_q == ST_IDLE) && start;
   assign load_second = (state_q == ST_GAP) && tick && (gap_q == '0);
   assign drive_bit   = in_bit && (sub_q == PH_LOW);
   assign sample_bit  = in_bit && (sub_q == PH_DATA);
   assign shift_bit   = in_bit && (sub_q == PH_HIGH) && !last_bit;
   assign end_frame   = in_bit && (sub_q == PH_HIGH) && last_bit;
   assign commit_rd   = end_frame && rd_q && second_q;

   always_comb begin
      if (!rd_q)          frame_last = CNT_W'(FR_WR - 1);
      else if (!second_q) frame_last = CNT_W'(FR_RA - 1);
      else                frame_last = CNT_W'(FR_RB - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         sub_q       <= PH_LOW;
         bits_left_q <= '0;
         gap_q       <= '0;
         rd_q        <= 1'b0;
         second_q    <= 1'b0;
         cs_n_q      <= 1'b1;
         sclk_q      <= 1'b1;
         done_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  rd_q     <= rd_nwr;
                  second_q <= 1'b0;
                  cs_n_q   <= 1'b0;
                  state_q  <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (tick) begin
                  state_q     <= ST_BIT;
                  sub_q       <= PH_LOW;
                  sclk_q      <= 1'b0;
                  bits_left_q <= frame_last;
               end
            end
            ST_BIT: begin
               if (tick) begin
                  case (sub_q)
                     PH_LOW: sub_q <= PH_DATA;
                     PH_DATA: begin
                        sub_q  <= PH_HIGH;
                        sclk_q <= 1'b1;
                     end
                     default: begin
                        if (!last_bit) begin
                           bits_left_q <= bits_left_q - 1'b1;
                           sub_q       <= PH_LOW;
                           sclk_q      <= 1'b0;
                        end else begin
                           cs_n_q <= 1'b1;
                           if (rd_q && !second_q) begin
                              state_q <= ST_GAP;
                              gap_q   <= GAP_W'(GAP_PHASES - 1);
                           end else begin
                              done_q  <= 1'b1;
                              state_q <= ST_IDLE;
                           end
                        end
                     end
                  endcase
               end
            end
            default: begin
               if (tick) begin
                  if (gap_q == '0) begin
                     cs_n_q   <= 1'b0;
                     second_q <= 1'b1;
                     state_q  <= ST_SETUP;
                  end else begin
                     gap_q <= gap_q - 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;
   assign cs_n = cs_n_q;
   assign sclk = sclk_q;

   assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && sclk));

   assert_clk_high_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !busy && !$past(cs_n)));
endmodule

// File: rtl/spiacc_shifter.sv
module spiacc_shifter #(
   parameter int unsigned CHIP_W = 7,
   parameter int unsigned MAP_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_first,
   input  logic              load_second,
   input  logic              rd_nwr,
   input  logic [CHIP_W-1:0] chip_addr,
   input  logic [MAP_W-1:0]  map_addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              drive_bit,
   input  logic              sample_bit,
   input  logic              shift_bit,
   input  logic              end_frame,
   input  logic              commit_rd,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned FR_W = CHIP_W + 1 + MAP_W + DATA_W;

   logic [FR_W-1:0]   tx_q;
   logic [CHIP_W-1:0] chip_q;
   logic [DATA_W-1:0] rx_q;
   logic [DATA_W-1:0] rdata_q;
   logic              mosi_q;
   logic [DATA_W-1:0] data_field;

   assign data_field = rd_nwr ? '0 : wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         chip_q <= '0;
      end else if (load_first) begin
         chip_q <= chip_addr;
         tx_q   <= {chip_addr, 1'b0, map_addr, data_field};
      end else if (load_second) begin
         tx_q   <= {chip_q, 1'b1, {(MAP_W + DATA_W){1'b0}}};
      end else if (shift_bit) begin
         tx_q   <= {tx_q[FR_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mosi_q <= 1'b0;
      end else if (drive_bit) begin
         mosi_q <= tx_q[FR_W-1];
      end else if (end_frame) begin
         mosi_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q    <= '0;
         rdata_q <= '0;
      end else begin
         if (sample_bit) rx_q <= {rx_q[DATA_W-2:0], miso};
         if (commit_rd)  rdata_q <= rx_q;
      end
   end

   assign mosi  = mosi_q;
   assign rdata = rdata_q;
endmodule

// File: rtl/spiacc_master.sv
module spiacc_master #(
   parameter int unsigned PHASE_CLKS = 4,
   parameter int unsigned GAP_PHASES = 1,
   parameter int unsigned CHIP_W     = 7,
   parameter int unsigned MAP_W      = 8,
   parameter int unsigned DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_nwr,
   input  logic [CHIP_W-1:0] chip_addr,
   input  logic [MAP_W-1:0]  map_addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              cs_n,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   localparam int unsigned HOLD_W = $clog2(PHASE_CLKS + 1);

   logic tick;
   logic load_first;
   logic load_second;
   logic drive_bit;
   logic sample_bit;
   logic shift_bit;
   logic end_frame;
   logic commit_rd;

   spiacc_phase_timer #(
      .PHASE_CLKS (PHASE_CLKS)
   ) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   spiacc_sequencer #(
      .CHIP_W     (CHIP_W),
      .MAP_W      (MAP_W),
      .DATA_W     (DATA_W),
      .GAP_PHASES (GAP_PHASES)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .start       (start),
      .rd_nwr      (rd_nwr),
      .busy        (busy),
      .done        (done),
      .cs_n        (cs_n),
      .sclk        (sclk),
      .load_first  (load_first),
      .load_second (load_second),
      .drive_bit   (drive_bit),
      .sample_bit  (sample_bit),
      .shift_bit   (shift_bit),
      .end_frame   (end_frame),
      .commit_rd   (commit_rd)
   );

   spiacc_shifter #(
      .CHIP_W (CHIP_W),
      .MAP_W  (MAP_W),
      .DATA_W (DATA_W)
   ) i_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_first  (load_first),
      .load_second (load_second),
      .rd_nwr      (rd_nwr),
      .chip_addr   (chip_addr),
      .map_addr    (map_addr),
      .wdata       (wdata),
      .drive_bit   (drive_bit),
      .sample_bit  (sample_bit),
      .shift_bit   (shift_bit),
      .end_frame   (end_frame),
      .commit_rd   (commit_rd),
      .miso        (miso),
      .mosi        (mosi),
      .rdata       (rdata)
   );

   // Run-length monitor of sclk for the phase-length check.
   logic              sclk_d;
   logic [HOLD_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b1;
         hold_q <= HOLD_W'(PHASE_CLKS);
      end else begin
         sclk_d <= sclk;
         if (sclk != sclk_d)                   hold_q <= HOLD_W'(1);
         else if (hold_q != HOLD_W'(PHASE_CLKS)) hold_q <= hold_q + 1'b1;
      end
   end

   assert_phase_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk != sclk_d) |-> (hold_q >= HOLD_W'(PHASE_CLKS)));

   assert_data_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk) && !cs_n && !$past(cs_n)) |-> $stable(mosi));

   assert_mosi_low_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !mosi);
endmodule

// File: tb/test_spiacc_master.sv
`timescale 1ns/1ps
module test_spiacc_master;
   localparam int P = 2;
   localparam int G = 2;
   localparam int WR_PH = 73;
   localparam int RD_PH = 98 + G;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       rd_nwr = 1'b0;
   logic [6:0] chip_addr = '0;
   logic [7:0] map_addr = '0;
   logic [7:0] wdata = '0;
   logic       busy, done, cs_n, sclk, mosi;
   logic [7:0] rdata;
   logic       miso = 1'b0;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   spiacc_master #(.PHASE_CLKS(P), .GAP_PHASES(G)) i_spiacc_master (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
      .chip_addr(chip_addr), .map_addr(map_addr), .wdata(wdata),
      .busy(busy), .done(done), .rdata(rdata),
      .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   // Behavioural receiver model
   logic [7:0]  slave_byte = '0;
   int          frame_total = 0;
   int          done_cnt = 0;
   int          f_len [0:3];
   logic [31:0] f_val [0:3];
   int          f_setup [0:3];
   int          f_gap [0:3];
   int          v3 = 0, v4 = 0, v11 = 0;
   logic        m_prev_cs = 1'b1, m_prev_sclk = 1'b1, m_prev_mosi = 1'b0;
   int          m_cnt = 0, m_setup = 0, m_hi = 0, m_gap_cur = 0;
   logic [31:0] m_bits = '0;
   logic        m_rd = 1'b0, m_fell = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (m_prev_cs && !cs_n) begin
            m_cnt = 0; m_bits = '0; m_rd = 1'b0; m_setup = 0; m_fell = 1'b0;
            m_gap_cur = m_hi; m_hi = 0;
         end
         if (cs_n) begin
            m_hi++;
            if (!sclk) v3++;
            if (mosi) v11++;
         end else begin
            if (!m_fell && sclk) m_setup++;
            if (sclk && m_prev_sclk && !m_prev_cs && mosi != m_prev_mosi) v4++;
            if (m_prev_sclk && !sclk) begin
               m_fell = 1'b1;
               if (m_rd && m_cnt >= 8 && m_cnt < 16) miso = slave_byte[15 - m_cnt];
            end
            if (!m_prev_sclk && sclk) begin
               m_bits = {m_bits[30:0], mosi};
               m_cnt++;
               if (m_cnt == 8) m_rd = mosi;
            end
         end
         if (!m_prev_cs && cs_n) begin
            f_len[frame_total % 4]   = m_cnt;
            f_val[frame_total % 4]   = m_bits;
            f_setup[frame_total % 4] = m_setup;
            f_gap[frame_total % 4]   = m_gap_cur;
            frame_total++;
            miso = 1'b0;
         end
         if (done) done_cnt++;
         m_prev_cs = cs_n; m_prev_sclk = sclk; m_prev_mosi = mosi;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [6:0] c, input logic [7:0] m, input logic [7:0] d, input bit inject);
      int base, dbase, n;
      logic [7:0] old_rd;
      base = frame_total; dbase = done_cnt; old_rd = rdata;
      @(negedge clk);
      start = 1'b1; rd_nwr = 1'b0; chip_addr = c; map_addr = m; wdata = d;
      @(negedge clk);
      start = 1'b0; n = 1;
      while (!done) begin
         @(negedge clk); n++;
         if (inject && n == 10) begin start = 1'b1; rd_nwr = 1'b1; chip_addr = ~c; map_addr = ~m; wdata = ~d; end
         if (inject && n == 11) start = 1'b0;
      end
      check(n == WR_PH * P + 1, "R3 write duration", n, WR_PH * P + 1);
      check(!busy, "R9 busy low with done", busy, 0);
      @(negedge clk);
      check(!done, "R9 done one cycle", done, 0);
      check(frame_total - base == 1, "R6 write frame count", frame_total - base, 1);
      check(f_len[base % 4] == 24, "R5 write bit count", f_len[base % 4], 24);
      check(f_val[base % 4] == {8'h00, c, 1'b0, m, d}, "R6 write frame value", f_val[base % 4], {8'h00, c, 1'b0, m, d});
      check(f_setup[base % 4] == P, "R10 setup phase", f_setup[base % 4], P);
      check(rdata == old_rd, "R12 rdata kept on write", rdata, old_rd);
      check(done_cnt - dbase == 1, "R9 done pulses", done_cnt - dbase, 1);
      if (inject) begin
         repeat (20) @(negedge clk);
         check(!busy && cs_n, "R2 start while busy ignored", {busy, cs_n}, 2'b01);
         check(frame_total - base == 1, "R2 no extra frame", frame_total - base, 1);
      end
   endtask

   task automatic do_read(input logic [6:0] c, input logic [7:0] m, input logic [7:0] b);
      int base, dbase, n;
      base = frame_total; dbase = done_cnt; slave_byte = b;
      @(negedge clk);
      start = 1'b1; rd_nwr = 1'b1; chip_addr = c; map_addr = m; wdata = 8'h5c;
      @(negedge clk);
      start = 1'b0; n = 1;
      check(busy && !cs_n, "R2 accepted from idle", {busy, cs_n}, 2'b10);
      while (!done) begin @(negedge clk); n++; end
      check(n == RD_PH * P + 1, "R3 read duration", n, RD_PH * P + 1);
      check(rdata == b, "R8 read byte", rdata, b);
      @(negedge clk);
      check(frame_total - base == 2, "R7 read frame count", frame_total - base, 2);
      check(f_len[base % 4] == 16 && f_len[(base + 1) % 4] == 16, "R5 read bit counts",
            {f_len[base % 4][15:0], f_len[(base + 1) % 4][15:0]}, 32'h00100010);
      check(f_val[base % 4] == {16'h0, c, 1'b0, m}, "R7 read address frame", f_val[base % 4], {16'h0, c, 1'b0, m});
      check(f_val[(base + 1) % 4] == {16'h0, c, 1'b1, 8'h00}, "R7 R11 read data frame",
            f_val[(base + 1) % 4], {16'h0, c, 1'b1, 8'h00});
      check(f_gap[(base + 1) % 4] == G * P, "R7 select gap", f_gap[(base + 1) % 4], G * P);
      check(f_setup[(base + 1) % 4] == P, "R10 setup second frame", f_setup[(base + 1) % 4], P);
      check(done_cnt - dbase == 1, "R9 one done per read", done_cnt - dbase, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n && sclk && !mosi && !busy && !done, "R1 reset levels",
            {cs_n, sclk, mosi, busy, done}, 5'b11000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(cs_n && sclk && !mosi && !busy && !done, "R1 idle levels",
            {cs_n, sclk, mosi, busy, done}, 5'b11000);
      for (int i = 0; i < 16; i++) begin
         logic [7:0] b;
         if (i == 0)      b = 8'h00;
         else if (i == 1) b = 8'hff;
         else if (i < 10) b = 8'h80 >> (i - 2);
         else             b = 8'(i * 37 + 3);
         do_read(7'h10 ^ 7'(i), 8'(i * 13), b);
      end
      for (int i = 0; i < 12; i++) begin
         logic [7:0] d;
         d = (i == 0) ? 8'h00 : (i == 1) ? 8'hff : 8'(8'hff - i * 29);
         do_write(7'h10 ^ 7'(i * 5), 8'(i * 17), d, i == 3);
      end
      check(v3 == 0, "R3 sclk high while deselected", v3, 0);
      check(v4 == 0, "R4 mosi stable while sclk high", v4, 0);
      check(v11 == 0, "R11 mosi low while deselected", v11, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule